// File: doc/BRIEF.md
# Byte-Lane Banked Memory Controller

This block sits behind a 16-bit data bus with a 20-bit byte address and splits storage into two byte-wide banks. One bank holds every even byte and carries data bits 7:0. The other holds every odd byte and carries bits 15:8. Address bit 0 (low for the even bank) and an active-low bus-high-enable (low for the odd bank) pick which lanes a transfer uses. The result is a single even byte, a single odd byte, or a full word in one cycle.

An address decoder compares the upper address bits against two aligned windows, a read-only region and a read/write region. Inside a window, the bank cell index is taken from address bits BANK_AW:1. Writes go to the read/write region only, through a separate write strobe per bank, so a byte write never disturbs the other lane. Reads need no per-lane strobe: whenever a read is active, both banks of the selected region drive the whole bus and the requester keeps the lane it wants. The read-only contents are placed into the arrays by a preload from the bench.

By default the read-only window starts at F0000h and the read/write window at C0000h. Each bank holds 2^BANK_AW bytes, with BANK_AW = 9 by default, so each window spans 1 Kbyte. Setting BANK_AW to 15 gives the full 64-Kbyte windows of 32-Kbyte bank chips.

Top module: `banked_mem_ctrl`

## Requirements
- R1: A write with address bit 0 = 0 and bhe_n = 1 stores wdata[7:0] into the even byte of the addressed word. The odd byte of that word is unchanged and wdata[15:8] is ignored.
- R2: A write with address bit 0 = 1 and bhe_n = 0 stores wdata[15:8] into the odd byte of the word at (address − 1). Bit 8 is the least significant bit of that byte. The even byte is unchanged.
- R3: A write with address bit 0 = 0 and bhe_n = 0 stores all 16 bits, odd byte from wdata[15:8] and even byte from wdata[7:0], in one clock edge.
- R4: A write with address bit 0 = 1 and bhe_n = 1 enables no bank and changes no stored byte.
- R5: While rd_n = 0 inside a region, rdata = {odd byte, even byte} of the word selected by address bits BANK_AW:1. This holds whatever the values of address bit 0 and bhe_n.
- R6: Addresses in [ROM_BASE, ROM_BASE + 2^(BANK_AW+1)) read the preloaded read-only contents. Writes there have no effect on any stored byte.
- R7: The read/write window is [RAM_BASE, RAM_BASE + 2^(BANK_AW+1)). Its last word is writable and readable. The bytes just below its base and just past its end lie in no region.
- R8: A read or write outside both windows raises out_of_range in the same cycle and returns rdata = 0. Such a write changes no stored byte. out_of_range is 0 when neither rd_n nor wr_n is low.
- R9: While rd_n = 1, rdata is 0.
- R10: A write takes effect on the rising clock edge at which wr_n = 0 and rst = 0. Read data shows the new value right after that edge and the old value before it. Writes while rst = 1 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes happen on its rising edge |
| rst | input | 1 | Synchronous active-high reset; blocks writes |
| addr | input | 20 | Byte address |
| bhe_n | input | 1 | Active-low enable of the odd (high) byte lane |
| rd_n | input | 1 | Active-low read |
| wr_n | input | 1 | Active-low write |
| wdata | input | 16 | Write data, odd lane on 15:8, even lane on 7:0 |
| rdata | output | 16 | Read data from both banks of the selected region |
| out_of_range | output | 1 | Access outside both windows |

## Verification
Read data, region decode and out_of_range are combinational, so the bench checks them 1 time unit after driving the inputs on the falling edge, inside the same cycle. Stored data changes only at the next rising edge. Each write is therefore followed by a read in a later cycle, and one test reads through the write cycle to see the old value before the edge and the new value after it. Tests that check a write had no effect read the same cell back through the read path before any other write can change it.

// File: rtl/bankmem_pkg.sv
package bankmem_pkg;

    localparam int ADDR_W = 20;
    localparam int LANE_W = 8;
    localparam int DATA_W = 2 * LANE_W;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_ROM  = 2'd1,
        RGN_RAM  = 2'd2
    } region_e;

    typedef struct packed {
        logic odd;
        logic even;
    } lane_pair_t;

    typedef struct packed {
        logic [LANE_W-1:0] odd;
        logic [LANE_W-1:0] even;
    } word_t;

    // true when address a falls in the aligned window of 2**span_lg2 bytes at base
    function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] base,
                                       input int unsigned span_lg2);
        logic [ADDR_W-1:0] mask;
        mask = ~((ADDR_W'(1) << span_lg2) - ADDR_W'(1));
        return (a & mask) == (base & mask);
    endfunction

endpackage

// File: rtl/bank_decode.sv
module bank_decode
    import bankmem_pkg::*;
#(
    parameter int              BANK_AW  = 9,
    parameter logic [ADDR_W-1:0] ROM_BASE = 20'hF0000,
    parameter logic [ADDR_W-1:0] RAM_BASE = 20'hC0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              bhe_n,
    input  logic              rd_n,
    input  logic              wr_n,
    output region_e           region,
    output lane_pair_t        wr_lane,
    output logic              out_of_range
);

    localparam int unsigned SPAN_LG2 = BANK_AW + 1;

    logic       rom_hit;
    logic       ram_hit;
    lane_pair_t lane_en;

    always_comb begin
        rom_hit = in_window(addr, ROM_BASE, SPAN_LG2);
        ram_hit = in_window(addr, RAM_BASE, SPAN_LG2);
        if (rom_hit)      region = RGN_ROM;
        else if (ram_hit) region = RGN_RAM;
        else              region = RGN_NONE;
    end

    always_comb begin
        lane_en.even = ~addr[0];
        lane_en.odd  = ~bhe_n;
    end

    always_comb begin
        wr_lane.even = ~wr_n & ~rst & lane_en.even & (region == RGN_RAM);
        wr_lane.odd  = ~wr_n & ~rst & lane_en.odd  & (region == RGN_RAM);
    end

    assign out_of_range = (~rd_n | ~wr_n) & (region == RGN_NONE);

    // R4
    no_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (addr[0] && bhe_n) |-> (wr_lane == 2'b00));

    // R6
    rom_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && rom_hit) |-> (wr_lane == 2'b00));

endmodule

// File: rtl/rom_bank.sv
module rom_bank
    import bankmem_pkg::*;
#(
    parameter int BANK_AW = 9
) (
    input  logic [BANK_AW-1:0] idx,
    output logic [LANE_W-1:0]  rd
);

    localparam int DEPTH = 1 << BANK_AW;

    logic [LANE_W-1:0] cells [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) cells[i] = '0;
    end

    assign rd = cells[idx];

endmodule

// File: rtl/ram_bank.sv
module ram_bank
    import bankmem_pkg::*;
#(
    parameter int BANK_AW = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [BANK_AW-1:0] idx,
    input  logic [LANE_W-1:0]  wd,
    output logic [LANE_W-1:0]  rd
);

    localparam int DEPTH = 1 << BANK_AW;

    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[idx] <= wd;
    end

    assign rd = cells[idx];

    // R10
    wr_lands_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (cells[$past(idx)] == $past(wd)));

    // R1
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> (cells[$past(idx)] == $past(cells[idx])));

endmodule

// File: rtl/banked_mem_ctrl.sv
module banked_mem_ctrl
    import bankmem_pkg::*;
#(
    parameter int              BANK_AW  = 9,
    parameter logic [ADDR_W-1:0] ROM_BASE = 20'hF0000,
    parameter logic [ADDR_W-1:0] RAM_BASE = 20'hC0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [19:0]       addr,
    input  logic              bhe_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              out_of_range
);

    region_e            region;
    lane_pair_t         wr_lane;
    logic [BANK_AW-1:0] idx;
    word_t              wr_word;
    word_t              rom_word;
    word_t              ram_word;
    word_t              rd_word;

    assign idx     = addr[BANK_AW:1];
    assign wr_word = wdata;

    bank_decode #(
        .BANK_AW (BANK_AW),
        .ROM_BASE(ROM_BASE),
        .RAM_BASE(RAM_BASE)
    ) u_decode (
        .clk         (clk),
        .rst         (rst),
        .addr        (addr),
        .bhe_n       (bhe_n),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .region      (region),
        .wr_lane     (wr_lane),
        .out_of_range(out_of_range)
    );

    rom_bank #(.BANK_AW(BANK_AW)) u_rom_even (.idx(idx), .rd(rom_word.even));
    rom_bank #(.BANK_AW(BANK_AW)) u_rom_odd  (.idx(idx), .rd(rom_word.odd));

    ram_bank #(.BANK_AW(BANK_AW)) u_ram_even (
        .clk(clk), .rst(rst), .we(wr_lane.even), .idx(idx),
        .wd(wr_word.even), .rd(ram_word.even)
    );
    ram_bank #(.BANK_AW(BANK_AW)) u_ram_odd (
        .clk(clk), .rst(rst), .we(wr_lane.odd), .idx(idx),
        .wd(wr_word.odd), .rd(ram_word.odd)
    );

    always_comb begin
        rd_word = '0;
        if (!rd_n) begin
            unique case (region)
                RGN_ROM: rd_word = rom_word;
                RGN_RAM: rd_word = ram_word;
                default: rd_word = '0;
            endcase
        end
    end

    assign rdata = rd_word;

    // R8
    oor_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        out_of_range |-> (rdata == 16'h0000 && wr_lane == 2'b00));

    // R9
    idle_rd_chk: assert property (@(posedge clk) disable iff (rst)
        rd_n |-> (rdata == 16'h0000));

endmodule

// File: tb/sim_banked_mem_ctrl.sv
module sim_banked_mem_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 512;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] addr = '0;
    logic        bhe_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        out_of_range;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_mem_ctrl u0 (
        .clk(clk), .rst(rst), .addr(addr), .bhe_n(bhe_n), .rd_n(rd_n),
        .wr_n(wr_n), .wdata(wdata), .rdata(rdata), .out_of_range(out_of_range)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [19:0] a, input logic bhe, input logic [15:0] d);
        @(negedge clk);
        addr = a; bhe_n = bhe; wdata = d; wr_n = 1'b0; rd_n = 1'b1;
        @(negedge clk);
        wr_n = 1'b1; bhe_n = 1'b1;
    endtask

    task automatic rd(input logic [19:0] a, input logic bhe, output logic [15:0] d, output logic oor);
        @(negedge clk);
        addr = a; bhe_n = bhe; rd_n = 1'b0; wr_n = 1'b1;
        #1;
        d = rdata; oor = out_of_range;
        @(negedge clk);
        rd_n = 1'b1;
    endtask

    function automatic logic [7:0] rom_even(input int i); return 8'(i) ^ 8'h3C; endfunction
    function automatic logic [7:0] rom_odd(input int i);  return 8'(i) + 8'h81; endfunction

    task automatic t_reset();
        #1;
        chk("R9 rdata idle in reset", rdata, 16'h0000);
        chk("R8 flag idle in reset", {15'd0, out_of_range}, 16'h0000);
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_lanes();
        logic [15:0] d; logic o;
        wr(20'hC0010, 1'b0, 16'h1234);
        rd(20'hC0010, 1'b0, d, o);
        chk("R3 word write", d, 16'h1234);
        wr(20'hC0010, 1'b1, 16'hAB55);
        rd(20'hC0010, 1'b0, d, o);
        chk("R1 even byte write", d, 16'h1255);
        wr(20'hC0011, 1'b0, 16'h9AFF);
        rd(20'hC0010, 1'b0, d, o);
        chk("R2 odd byte write", d, 16'h9A55);
        rd(20'hC0011, 1'b1, d, o);
        chk("R5 both lanes on odd read", d, 16'h9A55);
        wr(20'hC0011, 1'b1, 16'hFFFF);
        rd(20'hC0010, 1'b1, d, o);
        chk("R4 no-lane write ignored", d, 16'h9A55);
    endtask

    task automatic t_rom();
        logic [15:0] d; logic o;
        for (int i = 0; i < DEPTH; i++) begin
            u0.u_rom_even.cells[i] = rom_even(i);
            u0.u_rom_odd.cells[i]  = rom_odd(i);
        end
        rd(20'hF0000, 1'b0, d, o);
        chk("R6 rom word 0", d, {rom_odd(0), rom_even(0)});
        rd(20'hF03FF, 1'b0, d, o);
        chk("R6 rom last word", d, {rom_odd(511), rom_even(511)});
        wr(20'hC0004, 1'b0, 16'h4444);
        wr(20'hF0004, 1'b0, 16'h0000);
        rd(20'hF0004, 1'b0, d, o);
        chk("R6 rom write ignored", d, {rom_odd(2), rom_even(2)});
        rd(20'hC0004, 1'b0, d, o);
        chk("R6 ram untouched by rom write", d, 16'h4444);
    endtask

    task automatic t_edges();
        logic [15:0] d; logic o;
        wr(20'hC03FE, 1'b0, 16'hBEEF);
        rd(20'hC03FE, 1'b0, d, o);
        chk("R7 last ram word", d, 16'hBEEF);
        rd(20'hC0400, 1'b0, d, o);
        chk("R7 past end out of range", {15'd0, o}, 16'h0001);
        chk("R7 past end reads zero", d, 16'h0000);
        rd(20'hBFFFE, 1'b0, d, o);
        chk("R7 below base out of range", {15'd0, o}, 16'h0001);
    endtask

    task automatic t_oor();
        logic [15:0] d; logic o;
        @(negedge clk);
        addr = 20'h80004; bhe_n = 1'b0; wdata = 16'h7777; wr_n = 1'b0;
        #1;
        chk("R8 flag during stray write", {15'd0, out_of_range}, 16'h0001);
        @(negedge clk);
        wr_n = 1'b1; bhe_n = 1'b1;
        #1;
        chk("R8 flag low when idle", {15'd0, out_of_range}, 16'h0000);
        rd(20'hC0004, 1'b0, d, o);
        chk("R8 stray write ignored", d, 16'h4444);
        rd(20'h80004, 1'b0, d, o);
        chk("R8 stray read zero", d, 16'h0000);
    endtask

    task automatic t_timing();
        logic [15:0] d; logic o;
        wr(20'hC0020, 1'b0, 16'h1111);
        @(negedge clk);
        addr = 20'hC0020; bhe_n = 1'b0; wdata = 16'h5A5A; wr_n = 1'b0; rd_n = 1'b0;
        #1;
        chk("R10 old value before edge", rdata, 16'h1111);
        @(posedge clk);
        #1;
        chk("R10 new value after edge", rdata, 16'h5A5A);
        @(negedge clk);
        wr_n = 1'b1; rd_n = 1'b1; bhe_n = 1'b1;
        @(negedge clk);
        rst = 1'b1;
        addr = 20'hC0010; bhe_n = 1'b0; wdata = 16'h0000; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1; bhe_n = 1'b1; rst = 1'b0;
        rd(20'hC0010, 1'b0, d, o);
        chk("R10 write blocked in reset", d, 16'h9A55);
    endtask

    initial begin
        t_reset();
        t_lanes();
        t_rom();
        t_edges();
        t_oor();
        t_timing();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule